// File: doc/BRIEF.md
# PHY Event and Control Register

This block is one 8-bit register inside the physical layer of a serial bus node. It sits at a fixed address on a simple register port. It combines three groups of bits. Four sticky event flags record a looped bus, a cable power loss, a stuck arbitration state and a change in port status. Three plain control bits select watchdog reporting, accelerated arbitration and per-packet speed codes for concatenated packets. One request bit asks for an arbitrated short bus reset.

Event sources in the PHY core supply single-cycle pulses or levels. The register turns them into flags that software clears by writing ones. When a newly latched flag is allowed through, the block raises a one-cycle interrupt pulse toward the link controller.

Per-port status bits (connected, bias, disabled, fault) are watched for any change from one clock to the next. Such a change sets the port-event flag only while the interrupt enable is high. When the watchdog bit is set, a resume starting on any port also sets the port-event flag, and the interrupt fires whatever the interrupt enable says.

Top module: `phy_evt_csr`

## Requirements
- R1: After reset the register reads 0x08 (only the power-fail flag at bit 3 set), and `link_irq`, `sbr_req`, `accel_en` and `multi_spd_en` are 0.
- R2: Bit positions are: bit 0 watchdog, 1 short-reset request, 2 loop, 3 power fail, 4 arbitration timeout, 5 port event, 6 acceleration enable, 7 multi-speed enable. `rd_data` returns the register only when `addr` equals `REG_ADDR` (default 5) and returns 0 otherwise. Writes to any other address change nothing.
- R3: Bits 0, 6 and 7 take the written value. `accel_en` follows bit 6 and `multi_spd_en` follows bit 7.
- R4: Writing 1 to bit 1 sets it and raises `sbr_req` from the next cycle. Writing 0 leaves it set. It clears on the clock edge where `sbr_done` is high.
- R5: A `loop_det` pulse sets bit 2. Writing 1 to bit 2 clears it and writing 0 leaves it unchanged.
- R6: A 1-to-0 transition of `cable_pwr` sets bit 3. A 0-to-1 transition does not.
- R7: An `arb_timeout` pulse sets bit 4.
- R8: A change of any port's connected, bias, disabled or fault input sets bit 5 when `int_enable` is 1, and does not set it when `int_enable` is 0.
- R9: A `resume_start` pulse on any port sets bit 5 when the watchdog bit is 1, and does not set it when the watchdog bit is 0.
- R10: When an event and a write of 1 to the same flag arrive in one cycle, the flag ends set.
- R11: `link_irq` is high for exactly the one cycle that follows the edge at which a flag goes from 0 to 1. A flag that is already set raises no new pulse.
- R12: Loop, power-fail and timeout flags raise `link_irq` only while `int_enable` or the watchdog bit is 1. The port-event flag always raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (combinational) |
| loop_det | input | 1 | Loop detected pulse |
| cable_pwr | input | 1 | Cable power status level |
| arb_timeout | input | 1 | Arbitration state timeout pulse |
| int_enable | input | 1 | Interrupt enable level |
| resume_start | input | NUM_PORTS | Resume started, one bit per port |
| port_conn | input | NUM_PORTS | Per-port connected status |
| port_bias | input | NUM_PORTS | Per-port bias status |
| port_dis | input | NUM_PORTS | Per-port disabled status |
| port_fault | input | NUM_PORTS | Per-port fault status |
| sbr_done | input | 1 | Short bus reset completed pulse |
| sbr_req | output | 1 | Short bus reset request |
| accel_en | output | 1 | Arbitration acceleration enable |
| multi_spd_en | output | 1 | Multi-speed concatenation enable |
| link_irq | output | 1 | Interrupt pulse to link |

## Verification
Every flag and control bit is visible on `rd_data` in the same cycle it changes, so a wrongly held or wrongly cleared flag shows on the first read after the triggering edge. A broken port-status history register shows up one edge after a status input toggles, either as a missing port-event flag or as a spurious one. A wrong interrupt gate or a wrong edge detector shows as a missing, extra or two-cycle `link_irq` pulse in the cycle right after the flag sets. A stuck short-reset request shows on `sbr_req` at the edge after `sbr_done`.

// File: rtl/phy_evt_csr_pkg.sv
// Package: bit positions and reset value of the PHY event/control register.
// Assumes the flag bits (loop..port event) are contiguous starting at B_LOOP.
package phy_evt_csr_pkg;
    localparam int CSR_W     = 8;
    localparam int B_WDOG    = 0;
    localparam int B_SBR     = 1;
    localparam int B_LOOP    = 2;
    localparam int B_PWR     = 3;
    localparam int B_TMO     = 4;
    localparam int B_PEVT    = 5;
    localparam int B_ACCEL   = 6;
    localparam int B_MULTI   = 7;
    localparam int NUM_FLAGS = 4;
    // flag vector index = bit position - B_LOOP
    localparam int F_LOOP    = 0;
    localparam int F_PWR     = 1;
    localparam int F_TMO     = 2;
    localparam int F_PEVT    = 3;
    localparam logic [NUM_FLAGS-1:0] FLAG_RST = 4'b0010;
    localparam int STS_PER_PORT = 4;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/phy_evt_lvl_watch.sv
// Module: phy_evt_lvl_watch
// Flags, per lane, any difference between the live level and its value on
// the previous clock. Assumes the first clock after reset only primes the
// history, so no change is reported for levels that were already present.
module phy_evt_lvl_watch #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] chg_o
);
    logic [WIDTH-1:0] prev_q;
    logic             primed_q;

    // Keep last-cycle copy of each lane and note once history is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= lvl_i;
            primed_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        assign chg_o[i] = primed_q & (lvl_i[i] ^ prev_q[i]);
    end
endmodule

// File: rtl/phy_evt_flag_bit.sv
// Module: phy_evt_flag_bit
// One sticky event flag, cleared by software writing one. A set in the same
// cycle as a clear wins. Reports a combinational "newly set" indication.
module phy_evt_flag_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o,
    output logic newly_o
);
    logic flag_q;

    // Latch the event; clear only when no event is arriving.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= RST_VAL;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o  = flag_q;
    assign newly_o = set_i & ~flag_q;
endmodule

// File: rtl/phy_evt_irq_gen.sv
// Module: phy_evt_irq_gen
// Produces a registered one-cycle interrupt pulse when any flag is newly set
// and that flag is currently permitted to interrupt.
module phy_evt_irq_gen #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] newly_i,
    input  logic [N-1:0] permit_i,
    output logic         irq_o
);
    logic irq_q;

    // Pulse aligns with the cycle in which the flag first reads as set.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(newly_i & permit_i);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/phy_evt_csr.sv
// Module: phy_evt_csr (top)
// PHY event and control register: sticky write-one-to-clear event flags,
// plain control bits, a self-clearing short bus reset request, and a link
// interrupt pulse. Assumes event pulses are synchronous to clk and that the
// per-port status inputs are already synchronised levels.
module phy_evt_csr
    import phy_evt_csr_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 4,
    parameter int REG_ADDR  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic [CSR_W-1:0]     wr_data,
    output logic [CSR_W-1:0]     rd_data,
    input  logic                 loop_det,
    input  logic                 cable_pwr,
    input  logic                 arb_timeout,
    input  logic                 int_enable,
    input  logic [NUM_PORTS-1:0] resume_start,
    input  logic [NUM_PORTS-1:0] port_conn,
    input  logic [NUM_PORTS-1:0] port_bias,
    input  logic [NUM_PORTS-1:0] port_dis,
    input  logic [NUM_PORTS-1:0] port_fault,
    input  logic                 sbr_done,
    output logic                 sbr_req,
    output logic                 accel_en,
    output logic                 multi_spd_en,
    output logic                 link_irq
);
    localparam int STS_W = STS_PER_PORT * NUM_PORTS;

    logic             hit;
    logic             wr_hit;
    logic [STS_W-1:0] sts_vec;
    logic [STS_W-1:0] sts_chg;
    logic             pwr_chg;
    logic             pwr_fall;
    logic             wdog_q, sbr_q, accel_q, multi_q;
    flag_vec_t        flag_set, flag_clr, flag_val, flag_new, flag_permit;
    logic [CSR_W-1:0] csr_q;

    assign hit    = (addr == ADDR_W'(REG_ADDR));
    assign wr_hit = hit & wr_en;

    // Per-port status history: gather all four status kinds per port.
    assign sts_vec = {port_fault, port_dis, port_bias, port_conn};

    phy_evt_lvl_watch #(.WIDTH(STS_W)) u_sts_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (sts_vec),
        .chg_o (sts_chg)
    );

    phy_evt_lvl_watch #(.WIDTH(1)) u_pwr_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (cable_pwr),
        .chg_o (pwr_chg)
    );

    assign pwr_fall = pwr_chg & ~cable_pwr;

    // Event sources for each sticky flag.
    always_comb begin
        flag_set         = '0;
        flag_set[F_LOOP] = loop_det;
        flag_set[F_PWR]  = pwr_fall;
        flag_set[F_TMO]  = arb_timeout;
        flag_set[F_PEVT] = (int_enable & (|sts_chg)) | (wdog_q & (|resume_start));
    end

    // Interrupt permission per flag: port event is already gated at its source.
    always_comb begin
        flag_permit         = {NUM_FLAGS{int_enable | wdog_q}};
        flag_permit[F_PEVT] = 1'b1;
    end

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        assign flag_clr[f] = wr_hit & wr_data[B_LOOP + f];
        phy_evt_flag_bit #(.RST_VAL(FLAG_RST[f])) u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (flag_set[f]),
            .clr_i   (flag_clr[f]),
            .flag_o  (flag_val[f]),
            .newly_o (flag_new[f])
        );
    end

    // Plain control bits load from any write to this address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdog_q  <= 1'b0;
            accel_q <= 1'b0;
            multi_q <= 1'b0;
        end else if (wr_hit) begin
            wdog_q  <= wr_data[B_WDOG];
            accel_q <= wr_data[B_ACCEL];
            multi_q <= wr_data[B_MULTI];
        end
    end

    // Short reset request: set by writing one, dropped when the reset completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                        sbr_q <= 1'b0;
        else if (wr_hit & wr_data[B_SBR])  sbr_q <= 1'b1;
        else if (sbr_done)                 sbr_q <= 1'b0;
    end

    phy_evt_irq_gen #(.N(NUM_FLAGS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .newly_i  (flag_new),
        .permit_i (flag_permit),
        .irq_o    (link_irq)
    );

    // Assemble the register image in its software-visible bit order.
    always_comb begin
        csr_q          = '0;
        csr_q[B_WDOG]  = wdog_q;
        csr_q[B_SBR]   = sbr_q;
        csr_q[B_LOOP +: NUM_FLAGS] = flag_val;
        csr_q[B_ACCEL] = accel_q;
        csr_q[B_MULTI] = multi_q;
    end

    assign rd_data      = hit ? csr_q : '0;
    assign sbr_req      = sbr_q;
    assign accel_en     = accel_q;
    assign multi_spd_en = multi_q;
endmodule

// File: rtl/phy_evt_csr_chk.sv
// Module: phy_evt_csr_chk
// Checker bound into phy_evt_csr: relates events, writes and the register
// image across clock edges.
module phy_evt_csr_chk #(
    parameter int ADDR_W   = 4,
    parameter int REG_ADDR = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic              loop_det,
    input logic              arb_timeout,
    input logic              sbr_done,
    input logic              sbr_req,
    input logic              link_irq,
    input logic [7:0]        csr_q
);
    logic wr_hit;
    assign wr_hit = wr_en & (addr == ADDR_W'(REG_ADDR));

    AST_SBR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sbr_req && !sbr_done) |=> sbr_req); // R4
    AST_SBR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sbr_req && sbr_done && !(wr_hit && wr_data[1])) |=> !sbr_req); // R4
    AST_LOOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        loop_det |=> csr_q[2]); // R5
    AST_LOOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_q[2] && !(wr_hit && wr_data[2])) |=> csr_q[2]); // R5
    AST_TMO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        arb_timeout |=> csr_q[4]); // R7
    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        link_irq |-> (|csr_q[5:2])); // R11
endmodule

bind phy_evt_csr phy_evt_csr_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .loop_det    (loop_det),
    .arb_timeout (arb_timeout),
    .sbr_done    (sbr_done),
    .sbr_req     (sbr_req),
    .link_irq    (link_irq),
    .csr_q       (csr_q)
);

// File: tb/phy_evt_csr_tb_top.sv
`timescale 1ns/1ps
module phy_evt_csr_tb_top;
    localparam int NP = 3;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = 4'd5;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic [7:0]    rd_data;
    logic          loop_det = 1'b0, cable_pwr = 1'b1, arb_timeout = 1'b0, int_enable = 1'b0;
    logic [NP-1:0] resume_start = '0, port_conn = '0, port_bias = '0, port_dis = '0, port_fault = '0;
    logic          sbr_done = 1'b0;
    logic          sbr_req, accel_en, multi_spd_en, link_irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    phy_evt_csr #(.NUM_PORTS(NP), .ADDR_W(AW), .REG_ADDR(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .loop_det(loop_det), .cable_pwr(cable_pwr),
        .arb_timeout(arb_timeout), .int_enable(int_enable), .resume_start(resume_start),
        .port_conn(port_conn), .port_bias(port_bias), .port_dis(port_dis),
        .port_fault(port_fault), .sbr_done(sbr_done), .sbr_req(sbr_req),
        .accel_en(accel_en), .multi_spd_en(multi_spd_en), .link_irq(link_irq)
    );

    // Vector: [20] wr, [19:12] wdata, [11] loop, [10] timeout, [9] int_enable,
    //         [8:1] expected rd_data, [0] expected irq
    localparam int NV = 13;
    localparam logic [20:0] VECS [0:NV-1] = '{
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h08, 1'b0},
        {1'b1, 8'h08, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h04, 1'b0},
        {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h04, 1'b0},
        {1'b1, 8'h04, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h04, 1'b1},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h04, 1'b0},
        {1'b1, 8'h04, 1'b1, 1'b0, 1'b1, 8'h04, 1'b0},
        {1'b1, 8'h04, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h10, 1'b1},
        {1'b1, 8'hC1, 1'b0, 1'b0, 1'b0, 8'hD1, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hD5, 1'b1},
        {1'b1, 8'h14, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 rd_data", rd_data, 8'h08);
        chk("R1 irq/sbr/accel/multi", {4'h0, link_irq, sbr_req, accel_en, multi_spd_en}, 8'h00);
        rst_n = 1'b1;

        // Table walk: R5 R7 R10 R11 R12 and R3 control bits
        for (int i = 0; i < NV; i++) begin
            wr_en       = VECS[i][20];
            wr_data     = VECS[i][19:12];
            loop_det    = VECS[i][11];
            arb_timeout = VECS[i][10];
            int_enable  = VECS[i][9];
            step();
            chk($sformatf("R5/R10/R11/R12 vec%0d rd", i), rd_data, VECS[i][8:1]);
            chk($sformatf("R11 vec%0d irq", i), {7'h0, link_irq}, {7'h0, VECS[i][0]});
            wr_en = 1'b0; wr_data = 8'h00; loop_det = 1'b0; arb_timeout = 1'b0; int_enable = 1'b0;
        end

        // R2: other address reads zero, writes there are ignored
        addr = 4'd3;
        #1 chk("R2 other addr read", rd_data, 8'h00);
        wr(8'hFF);
        addr = 4'd5;
        #1 chk("R2 write elsewhere ignored", rd_data, 8'h00);

        // R3: control bits drive outputs
        wr(8'hC0);
        chk("R3 rd", rd_data, 8'hC0);
        chk("R3 outs", {6'h0, accel_en, multi_spd_en}, 8'h03);
        wr(8'h40);
        chk("R3 outs after 0x40", {6'h0, accel_en, multi_spd_en}, 8'h02);
        wr(8'h00);

        // R4: short reset request
        wr(8'h02);
        chk("R4 set", {rd_data[7:2], 1'b0, sbr_req}, 8'h01);
        chk("R4 rd bit", rd_data, 8'h02);
        wr(8'h00);
        chk("R4 write0 holds", {7'h0, sbr_req}, 8'h01);
        sbr_done = 1'b1; step(); sbr_done = 1'b0;
        chk("R4 cleared by done", {rd_data[7:1], sbr_req}, 8'h00);

        // R6: cable power falling edge only
        int_enable = 1'b1;
        cable_pwr = 1'b0; step();
        chk("R6 fall sets", rd_data, 8'h08);
        chk("R6 irq", {7'h0, link_irq}, 8'h01);
        step();
        chk("R11 single pulse", {7'h0, link_irq}, 8'h00);
        wr(8'h08);
        chk("R6 cleared", rd_data, 8'h00);
        cable_pwr = 1'b1; step();
        chk("R6 rise ignored", rd_data, 8'h00);

        // R8: port status changes gated by int_enable
        port_conn[1] = 1'b1; step();
        chk("R8 change sets", rd_data, 8'h20);
        chk("R8 irq", {7'h0, link_irq}, 8'h01);
        wr(8'h20);
        chk("R8 cleared", rd_data, 8'h00);
        int_enable = 1'b0;
        port_fault[0] = 1'b1; step();
        chk("R8 gated off", rd_data, 8'h00);
        port_fault[0] = 1'b0; step();
        chk("R8 gated off back", rd_data, 8'h00);
        int_enable = 1'b1;
        port_bias[2] = 1'b1; step();
        chk("R8 bias change", rd_data, 8'h20);
        int_enable = 1'b0;
        wr(8'h20);

        // R9: resume gated by watchdog bit
        wr(8'h01);
        resume_start[2] = 1'b1; step(); resume_start = '0;
        chk("R9 resume with watchdog", rd_data, 8'h21);
        chk("R9 irq without int_enable", {7'h0, link_irq}, 8'h01);
        wr(8'h21);
        chk("R9 cleared keeps watchdog", rd_data, 8'h01);
        wr(8'h00);
        resume_start[0] = 1'b1; step(); resume_start = '0;
        chk("R9 resume no watchdog", rd_data, 8'h00);

        // R12: timeout with no permission raises no interrupt
        arb_timeout = 1'b1; step(); arb_timeout = 1'b0;
        chk("R12 flag set", rd_data, 8'h10);
        chk("R12 no irq", {7'h0, link_irq}, 8'h00);
        wr(8'h10);

        finish_run();
    end
endmodule